// File: doc/BRIEF.md
# Load-Use Hazard Stall Unit

This block is the front of a five-stage in-order scalar pipeline (fetch, register read, execute, data fetch, writeback). It owns the fetch program counter, the fetch-to-decode latch and the decode-to-execute latch. Each cycle it checks whether the instruction in decode reads a register that a load in execute has not yet produced. When it does, the block puts a bubble into the decode-to-execute latch and leaves fetch idle for that cycle.

An external decoder looks at `dec_word` and returns the opcode id, the operand-usage flags and a load flag for the instruction in decode. The block carries the load flag forward into the execute latch and uses it in the next cycle. The destination register of the load now in execute comes from the execute stage on `ex_dest`. The bubble is a shift-left-logical opcode (id `BUBBLE_OP`, default 0) with an all-zero instruction word. A bubble is never a load, so a stall always lasts exactly one cycle.

A two-state controller sets the sequencing. `ST_FLOW` is the normal advancing state. The transition FLOW→BUBBLE is taken when a hazard is detected. `ST_BUBBLE` is the cycle after a stall, and its transition BUBBLE→FLOW is unconditional. The program counter steps by 4 and wraps inside a 4 KB instruction memory.

Top module: `lu_stall_unit`

## Requirements
- R1: `stall` is high only when the decode-to-execute latch holds a load (`dx_is_load` = 1).
- R2: A load destination of register 0 (`ex_dest` = 0) never raises `stall`.
- R3: `stall` is high, apart from the cases in R1, R2 and R9, exactly when one of two conditions holds. The first is `ex_dest` equal to `dec_word[25:21]` (rs) with `dec_need_rs` = 1. The second is `ex_dest` equal to `dec_word[20:16]` (rt) with `dec_need_rt` = 1.
- R4: After a clock edge with `stall` high, the execute latch holds the bubble: `dx_op` = `BUBBLE_OP` (0), `dx_word` = 0, `dx_is_load` = 0, and `dx_pc` equal to the `dec_pc` of that cycle.
- R5: After a clock edge with `stall` high, `imem_addr`, `dec_word` and `dec_pc` keep their values.
- R6: After a clock edge with `stall` low and reset low, `imem_addr` increases by 4 modulo 4096, so 0xFFC is followed by 0x000.
- R7: After a clock edge with `stall` low, `dec_word`/`dec_pc` take `imem_rdata` and the address it was read from. The execute latch takes `dec_op`, `dec_word`, `dec_pc` and `dec_is_load`.
- R8: A synchronous reset (`rst` = 1 at a clock edge) sets `imem_addr`, `dec_word`, `dec_pc`, `dx_word` and `dx_pc` to 0, `dx_op` to `BUBBLE_OP`, and `dx_is_load` to 0.
- R9: `stall` is never high in two consecutive cycles.
- R10: `imem_addr[1:0]` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| imem_rdata | input | 32 | Instruction word read at `imem_addr` |
| dec_op | input | 6 | Opcode id decoded from `dec_word` |
| dec_need_rs | input | 1 | Decoded instruction reads rs |
| dec_need_rt | input | 1 | Decoded instruction reads rt |
| dec_is_load | input | 1 | Decoded instruction is a load |
| ex_dest | input | 5 | Destination register of the instruction in execute |
| imem_addr | output | 12 | Fetch program counter |
| dec_word | output | 32 | Fetch-to-decode latch: instruction word |
| dec_pc | output | 12 | Fetch-to-decode latch: its address |
| dx_op | output | 6 | Decode-to-execute latch: opcode id |
| dx_word | output | 32 | Decode-to-execute latch: instruction word |
| dx_pc | output | 12 | Decode-to-execute latch: address |
| dx_is_load | output | 1 | Decode-to-execute latch: load flag |
| stall | output | 1 | Hazard stall to fetch, this cycle |

## Verification
The bench drives `ex_dest` with the rs field, the rt field, zero or a random value of the word in decode, and sets the usage flags independently. This covers a match on a field whose flag is clear, where a design that ignored the flags would stall without need. It also covers the zero register, which a design that forgot the zero test would stall on. The run is long enough for the counter to wrap several times: a counter that did not wrap, or that advanced by the wrong step, would fetch wrong addresses. A mid-run reset and back-to-back load hazards test that the bubble clears the load flag. A design that left the flag set would stall twice or would replay the load word.

// File: rtl/lu_pkg.sv
package lu_pkg;
    typedef enum logic [0:0] {
        ST_FLOW   = 1'b0,
        ST_BUBBLE = 1'b1
    } lu_state_e;

    function automatic logic field_hit(input logic [4:0] dest,
                                       input logic [4:0] field,
                                       input logic       needed);
        return needed && (dest == field);
    endfunction
endpackage

// File: rtl/lu_hazard_detect.sv
module lu_hazard_detect #(
    parameter int IW     = 32,
    parameter int RW     = 5,
    parameter int RS_LSB = 21,
    parameter int RT_LSB = 16
) (
    input  logic [IW-1:0] word,
    input  logic          need_rs,
    input  logic          need_rt,
    input  logic          ex_load,
    input  logic [RW-1:0] ex_dest,
    output logic          hazard
);
    localparam logic [RW-1:0] ZERO_REG = '0;

    logic [RW-1:0] rs_field;
    logic [RW-1:0] rt_field;
    logic          rs_hit;
    logic          rt_hit;

    always_comb begin
        rs_field = word[RS_LSB +: RW];
        rt_field = word[RT_LSB +: RW];
        rs_hit   = need_rs && (ex_dest == rs_field);
        rt_hit   = need_rt && (ex_dest == rt_field);
        hazard   = ex_load && (ex_dest != ZERO_REG) && (rs_hit || rt_hit);
    end
endmodule

// File: rtl/lu_fetch_pc.sv
module lu_fetch_pc #(
    parameter int PC_W = 12,
    parameter int IB   = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hold,
    output logic [PC_W-1:0] pc
);
    localparam logic [PC_W-1:0] STEP = PC_W'(IB);
    localparam logic [PC_W-1:0] MASK = ~PC_W'(IB - 1);

    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_d;

    always_comb begin
        if (hold) pc_d = pc_q;
        else      pc_d = (pc_q + STEP) & MASK;
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_d;
    end

    assign pc = pc_q;
endmodule

// File: rtl/lu_pipe_latches.sv
module lu_pipe_latches #(
    parameter int                IW        = 32,
    parameter int                PC_W      = 12,
    parameter int                OP_W      = 6,
    parameter logic [OP_W-1:0]   BUBBLE_OP = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            kill,
    input  logic [IW-1:0]   fetch_word,
    input  logic [PC_W-1:0] fetch_pc,
    input  logic [OP_W-1:0] dec_op,
    input  logic            dec_is_load,
    output logic [IW-1:0]   fd_word,
    output logic [PC_W-1:0] fd_pc,
    output logic [OP_W-1:0] dx_op,
    output logic [IW-1:0]   dx_word,
    output logic [PC_W-1:0] dx_pc,
    output logic            dx_is_load
);
    // fetch-to-decode stage: holds while killed
    always_ff @(posedge clk) begin
        if (rst) begin
            fd_word <= '0;
            fd_pc   <= '0;
        end else if (!kill) begin
            fd_word <= fetch_word;
            fd_pc   <= fetch_pc;
        end
    end

    // decode-to-execute stage: bubble while killed
    always_ff @(posedge clk) begin
        if (rst) begin
            dx_op      <= BUBBLE_OP;
            dx_word    <= '0;
            dx_pc      <= '0;
            dx_is_load <= 1'b0;
        end else if (kill) begin
            dx_op      <= BUBBLE_OP;
            dx_word    <= '0;
            dx_pc      <= fd_pc;
            dx_is_load <= 1'b0;
        end else begin
            dx_op      <= dec_op;
            dx_word    <= fd_word;
            dx_pc      <= fd_pc;
            dx_is_load <= dec_is_load;
        end
    end
endmodule

// File: rtl/lu_stall_unit.sv
module lu_stall_unit #(
    parameter int              IW        = 32,
    parameter int              PC_W      = 12,
    parameter int              OP_W      = 6,
    parameter int              RW        = 5,
    parameter int              RS_LSB    = 21,
    parameter int              RT_LSB    = 16,
    parameter logic [OP_W-1:0] BUBBLE_OP = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [IW-1:0]   imem_rdata,
    input  logic [OP_W-1:0] dec_op,
    input  logic            dec_need_rs,
    input  logic            dec_need_rt,
    input  logic            dec_is_load,
    input  logic [RW-1:0]   ex_dest,
    output logic [PC_W-1:0] imem_addr,
    output logic [IW-1:0]   dec_word,
    output logic [PC_W-1:0] dec_pc,
    output logic [OP_W-1:0] dx_op,
    output logic [IW-1:0]   dx_word,
    output logic [PC_W-1:0] dx_pc,
    output logic            dx_is_load,
    output logic            stall
);
    import lu_pkg::*;

    localparam int IB = IW / 8;

    lu_state_e state_q;
    lu_state_e state_d;
    logic      hazard;

    lu_hazard_detect #(
        .IW(IW), .RW(RW), .RS_LSB(RS_LSB), .RT_LSB(RT_LSB)
    ) u_detect (
        .word    (dec_word),
        .need_rs (dec_need_rs),
        .need_rt (dec_need_rt),
        .ex_load (dx_is_load),
        .ex_dest (ex_dest),
        .hazard  (hazard)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FLOW;
        else     state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        stall   = 1'b0;
        unique case (state_q)
            ST_FLOW: begin
                stall = hazard;
                if (hazard) state_d = ST_BUBBLE;
            end
            ST_BUBBLE: begin
                stall   = 1'b0;
                state_d = ST_FLOW;
            end
            default: begin
                stall   = 1'b0;
                state_d = ST_FLOW;
            end
        endcase
    end

    lu_fetch_pc #(.PC_W(PC_W), .IB(IB)) u_pc (
        .clk  (clk),
        .rst  (rst),
        .hold (stall),
        .pc   (imem_addr)
    );

    lu_pipe_latches #(
        .IW(IW), .PC_W(PC_W), .OP_W(OP_W), .BUBBLE_OP(BUBBLE_OP)
    ) u_latch (
        .clk         (clk),
        .rst         (rst),
        .kill        (stall),
        .fetch_word  (imem_rdata),
        .fetch_pc    (imem_addr),
        .dec_op      (dec_op),
        .dec_is_load (dec_is_load),
        .fd_word     (dec_word),
        .fd_pc       (dec_pc),
        .dx_op       (dx_op),
        .dx_word     (dx_word),
        .dx_pc       (dx_pc),
        .dx_is_load  (dx_is_load)
    );
endmodule

// File: rtl/lu_stall_unit_checker.sv
module lu_stall_unit_checker #(
    parameter int              IW        = 32,
    parameter int              PC_W      = 12,
    parameter int              OP_W      = 6,
    parameter int              RW        = 5,
    parameter logic [OP_W-1:0] BUBBLE_OP = '0
) (
    input logic            clk,
    input logic            rst,
    input logic [RW-1:0]   ex_dest,
    input logic [PC_W-1:0] imem_addr,
    input logic [IW-1:0]   dec_word,
    input logic [PC_W-1:0] dec_pc,
    input logic [OP_W-1:0] dx_op,
    input logic [IW-1:0]   dx_word,
    input logic [PC_W-1:0] dx_pc,
    input logic            dx_is_load,
    input logic            stall
);
    localparam logic [PC_W-1:0] STEP = PC_W'(IW / 8);

    assert_load_only_R1: assert property (@(posedge clk) disable iff (rst)
        stall |-> dx_is_load);

    assert_zero_dest_R2: assert property (@(posedge clk) disable iff (rst)
        stall |-> (ex_dest != '0));

    assert_bubble_R4: assert property (@(posedge clk) disable iff (rst)
        stall |=> (dx_op == BUBBLE_OP) && (dx_word == '0) && !dx_is_load
                  && (dx_pc == $past(dec_pc)));

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(imem_addr) && $stable(dec_word) && $stable(dec_pc));

    assert_advance_R6: assert property (@(posedge clk) disable iff (rst)
        !stall |=> imem_addr == $past(imem_addr) + STEP);

    assert_fetch_pc_R7: assert property (@(posedge clk) disable iff (rst)
        !stall |=> dec_pc == $past(imem_addr));

    assert_reset_R8: assert property (@(posedge clk)
        rst |=> (imem_addr == '0) && (dx_op == BUBBLE_OP) && !dx_is_load);

    assert_single_R9: assert property (@(posedge clk) disable iff (rst)
        stall |=> !stall);

    assert_align_R10: assert property (@(posedge clk) disable iff (rst)
        imem_addr[1:0] == 2'b00);
endmodule

bind lu_stall_unit lu_stall_unit_checker #(
    .IW(IW), .PC_W(PC_W), .OP_W(OP_W), .RW(RW), .BUBBLE_OP(BUBBLE_OP)
) u_checker (
    .clk        (clk),
    .rst        (rst),
    .ex_dest    (ex_dest),
    .imem_addr  (imem_addr),
    .dec_word   (dec_word),
    .dec_pc     (dec_pc),
    .dx_op      (dx_op),
    .dx_word    (dx_word),
    .dx_pc      (dx_pc),
    .dx_is_load (dx_is_load),
    .stall      (stall)
);

// File: tb/lu_stall_unit_bench.sv
module lu_stall_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_rdata;
    logic [5:0]  dec_op = '0;
    logic        dec_need_rs = 1'b0;
    logic        dec_need_rt = 1'b0;
    logic        dec_is_load = 1'b0;
    logic [4:0]  ex_dest = '0;
    logic [11:0] imem_addr;
    logic [31:0] dec_word;
    logic [11:0] dec_pc;
    logic [5:0]  dx_op;
    logic [31:0] dx_word;
    logic [11:0] dx_pc;
    logic        dx_is_load;
    logic        stall;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    function automatic logic [31:0] mem_fn(input logic [11:0] a);
        return {a[7:2] ^ 6'h15, a[6:2], a[10:6], a, 4'h9};
    endfunction

    assign imem_rdata = mem_fn(imem_addr);

    lu_stall_unit u_lu_stall_unit (
        .clk(clk), .rst(rst), .imem_rdata(imem_rdata), .dec_op(dec_op),
        .dec_need_rs(dec_need_rs), .dec_need_rt(dec_need_rt),
        .dec_is_load(dec_is_load), .ex_dest(ex_dest),
        .imem_addr(imem_addr), .dec_word(dec_word), .dec_pc(dec_pc),
        .dx_op(dx_op), .dx_word(dx_word), .dx_pc(dx_pc),
        .dx_is_load(dx_is_load), .stall(stall)
    );

    // reference model state
    int m_pc, m_fp, m_op, m_p, m_ld;
    logic [31:0] m_fw, m_w;
    bit known = 0;
    int stalls_seen = 0;
    int wraps_seen  = 0;

    task automatic cmp(input string req, input string what,
                       input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_pc = 0; m_fp = 0; m_fw = '0;
        m_op = 0; m_w = '0; m_p = 0; m_ld = 0;
    endtask

    // one cycle: check registered state, drive inputs, check stall, step model
    task automatic cycle(input bit r, input int mode);
        bit exp_stall;
        logic [4:0] rsf, rtf;
        @(negedge clk);
        if (known) begin
            // R8 reset values, R4 bubble, R5 hold, R6 step, R7 capture, R10
            cmp("R6/R10", "imem_addr", imem_addr, m_pc);
            cmp("R5/R7", "dec_word", dec_word, m_fw);
            cmp("R5/R7", "dec_pc", dec_pc, m_fp);
            cmp("R4/R7/R8", "dx_op", dx_op, m_op);
            cmp("R4/R7/R8", "dx_word", dx_word, m_w);
            cmp("R4/R7/R8", "dx_pc", dx_pc, m_p);
            cmp("R1/R4/R8", "dx_is_load", dx_is_load, m_ld);
        end
        rst = r;
        rsf = m_fw[25:21];
        rtf = m_fw[20:16];
        dec_op      = 6'($urandom_range(1, 63));
        dec_need_rs = 1'($urandom);
        dec_need_rt = 1'($urandom);
        dec_is_load = ($urandom_range(0, 9) < 5);
        unique case (mode)
            0: ex_dest = rsf;
            1: ex_dest = rtf;
            2: ex_dest = '0;
            default: ex_dest = 5'($urandom);
        endcase
        #1;
        // R1, R2, R3, R9: expected stall from decode fields and flags
        exp_stall = !r && (m_ld != 0) && (ex_dest != 0) &&
                    ((dec_need_rs && ex_dest == rsf) ||
                     (dec_need_rt && ex_dest == rtf));
        if (known && !r) cmp("R1/R2/R3/R9", "stall", stall, exp_stall);
        if (r) begin
            model_reset();
            known = 1;
        end else if (exp_stall) begin
            stalls_seen++;
            m_op = 0; m_w = '0; m_p = m_fp; m_ld = 0;
        end else begin
            m_op = dec_op; m_w = m_fw; m_p = m_fp; m_ld = dec_is_load;
            m_fw = mem_fn(12'(m_pc)); m_fp = m_pc;
            if (m_pc == 12'hFFC) wraps_seen++;
            m_pc = (m_pc + 4) % 4096;
        end
    endtask

    initial begin
        cycle(1, 3);
        cycle(1, 3);
        // R2: zero destination with loads only
        for (int i = 0; i < 200; i++) cycle(0, 2);
        // R3: rs / rt matches and random, across several wraps (R6)
        for (int i = 0; i < 4000; i++) cycle(0, $urandom_range(0, 3));
        // R8: reset in mid-run then continue
        cycle(1, 0);
        for (int i = 0; i < 2000; i++) cycle(0, $urandom_range(0, 1));
        @(negedge clk);
        vectors++;
        if (stalls_seen < 20) begin
            fails++;
            $display("FAIL R3 coverage: actual %0d stalls expected >= 20", stalls_seen);
        end
        vectors++;
        if (wraps_seen < 2) begin
            fails++;
            $display("FAIL R6 coverage: actual %0d wraps expected >= 2", wraps_seen);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule